// File: doc/BRIEF.md
# Time-Sliced Four-Motor H-Bridge PWM Generator

This block produces the gate-enable pair for four brushed-motor H-bridges from an 8-bit speed word and a direction bit per motor. A free-running sequencer divides time into a repeating frame of four equal slots. With the default settings this is a 32 µs frame of four 8 µs slots at 25 MHz. Each motor may conduct only inside its own slot. Because the bus voltage is four times the motor rating, a 25% duty ceiling is exactly full motor power, and only one motor ever draws current from the supply at a time.

At the start of its slot, each channel captures its speed and direction. It clamps the speed to the slot length and then runs a down-counter. For as many clocks as the clamped command, it drives either the A input (forward) or the B input (reverse). Every active phase has one clock with both inputs low before it and one after it. An active-low fault input per channel from the current-sense comparators cuts that channel's drive within one clock. The drive then stays off until that channel's next slot start.

Top module: `tslot_hbridge_pwm`

## Requirements
- R1: Count the first rising clock edge after reset is released as edge 1, and let FRAME = NUM_CH*SLOT_CLKS. Channel k captures its command at edges 2 + k*SLOT_CLKS + f*FRAME, for f = 0, 1, 2, and so on. Channel 0 therefore captures first.
- R2: After a capture with clamped value N, the channel's active output is high after each of the N edges that follow the capture edge, and low otherwise.
- R3: A speed value of 0 produces no active phase. A speed value above MAX_ON behaves exactly like MAX_ON.
- R4: dir_fwd = 1 makes the active phase drive drv_a high with drv_b low. dir_fwd = 0 drives drv_b high with drv_a low. Outside the active phase, both outputs are low.
- R5: Both outputs of a channel are low in the cycle after its capture edge and in the cycle after its last active cycle. An output never passes directly from A high to B high, or from B high to A high.
- R6: drv_a and drv_b of one channel are never high together, and at most one channel drives an output high in any cycle.
- R7: Speed and direction changes between capture edges do not alter a pulse that has already been captured.
- R8: If fault_n of a channel is sampled low at any edge, both of its outputs are low after that edge. They stay low until that channel's next capture. A fault sampled low at the capture edge suppresses the whole pulse.
- R9: While rst is high and after the edge that applies it, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_cmd | input | NUM_CH*CMD_W | Per-channel speed word, channel k at bits [k*CMD_W +: CMD_W] |
| dir_fwd | input | NUM_CH | Per-channel direction, 1 = forward (A side) |
| fault_n | input | NUM_CH | Per-channel overcurrent flag, active low |
| drv_a | output | NUM_CH | A half-bridge enable per channel |
| drv_b | output | NUM_CH | B half-bridge enable per channel |

## Verification
The first pattern is an exhaustive sweep of every speed value in both directions. The sweep separates exact pulse width, zero suppression and clamping above the ceiling, and it shows any A/B swap. The second pattern changes speed and direction on every clock. Only capture-edge sampling survives it, so it exposes any channel that reloads or resteers mid-pulse. The third pattern is a pseudo-random scatter of fault pulses, including one held across a capture. It separates a cut that stays latched for the rest of the slot from one that releases early or misses the capture-time case.

// File: rtl/tslot_pwm_pkg.sv
package tslot_pwm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_ACT  = 2'd2,
    PH_TAIL = 2'd3
  } phase_e;

  function automatic int clog2_min1(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/tslot_sequencer.sv
module tslot_sequencer
  import tslot_pwm_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int SLOT_CLKS = 200
) (
  input  logic              clk,
  input  logic              rst,
  output logic [NUM_CH-1:0] slot_start
);

  localparam int SW  = clog2_min1(SLOT_CLKS);
  localparam int CHW = clog2_min1(NUM_CH);
  localparam logic [SW-1:0]  SLOT_LAST = SW'(SLOT_CLKS - 1);
  localparam logic [CHW-1:0] CH_LAST   = CHW'(NUM_CH - 1);

  logic [SW-1:0]  slot_cnt;
  logic [CHW-1:0] ch_idx;

  // slot position and owning channel
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_cnt <= '0;
      ch_idx   <= '0;
    end else if (slot_cnt == SLOT_LAST) begin
      slot_cnt <= '0;
      ch_idx   <= (ch_idx == CH_LAST) ? '0 : ch_idx + 1'b1;
    end else begin
      slot_cnt <= slot_cnt + 1'b1;
    end
  end

  // one registered strobe per channel at its slot boundary
  for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (rst) slot_start[g] <= 1'b0;
      else     slot_start[g] <= (slot_cnt == '0) && (ch_idx == CHW'(g));
    end
  end

endmodule

// File: rtl/hbridge_channel.sv
module hbridge_channel
  import tslot_pwm_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int MAX_ON = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CMD_W-1:0] cmd,
  input  logic             fwd,
  input  logic             fault_n,
  output logic             out_a,
  output logic             out_b
);

  localparam int CW = clog2_min1(MAX_ON + 1);
  localparam logic [CMD_W-1:0] CAP = CMD_W'(MAX_ON);

  phase_e           ph, ph_n;
  logic [CW-1:0]    cnt, cnt_n;
  logic             dir_q, dir_n;
  logic             kill_q, kill_n;
  logic [CMD_W-1:0] cmd_clamp;

  always_comb begin
    cmd_clamp = (cmd > CAP) ? CAP : cmd;
    ph_n      = ph;
    cnt_n     = cnt;
    dir_n     = dir_q;
    kill_n    = kill_q | ~fault_n;
    if (start) begin
      // capture point: everything for this slot is taken here
      dir_n  = fwd;
      kill_n = ~fault_n;
      cnt_n  = CW'(cmd_clamp);
      ph_n   = (cmd_clamp == '0) ? PH_IDLE : PH_LEAD;
    end else begin
      case (ph)
        PH_LEAD: ph_n = PH_ACT;
        PH_ACT: begin
          cnt_n = cnt - 1'b1;
          if (cnt == CW'(1)) ph_n = PH_TAIL;
        end
        PH_TAIL: ph_n = PH_IDLE;
        default: ph_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      dir_q  <= 1'b0;
      kill_q <= 1'b0;
      out_a  <= 1'b0;
      out_b  <= 1'b0;
    end else begin
      ph     <= ph_n;
      cnt    <= cnt_n;
      dir_q  <= dir_n;
      kill_q <= kill_n;
      out_a  <= (ph_n == PH_ACT) &&  dir_n && !kill_n;
      out_b  <= (ph_n == PH_ACT) && !dir_n && !kill_n;
    end
  end

endmodule

// File: rtl/tslot_hbridge_pwm.sv
module tslot_hbridge_pwm #(
  parameter int NUM_CH    = 4,
  parameter int CMD_W     = 8,
  parameter int SLOT_CLKS = 200,
  parameter int MAX_ON    = 200
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH*CMD_W-1:0] speed_cmd,
  input  logic [NUM_CH-1:0]       dir_fwd,
  input  logic [NUM_CH-1:0]       fault_n,
  output logic [NUM_CH-1:0]       drv_a,
  output logic [NUM_CH-1:0]       drv_b
);

  logic [NUM_CH-1:0] slot_start;

  tslot_sequencer #(
    .NUM_CH   (NUM_CH),
    .SLOT_CLKS(SLOT_CLKS)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .slot_start(slot_start)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    hbridge_channel #(
      .CMD_W (CMD_W),
      .MAX_ON(MAX_ON)
    ) ch_i (
      .clk    (clk),
      .rst    (rst),
      .start  (slot_start[g]),
      .cmd    (speed_cmd[g*CMD_W +: CMD_W]),
      .fwd    (dir_fwd[g]),
      .fault_n(fault_n[g]),
      .out_a  (drv_a[g]),
      .out_b  (drv_b[g])
    );
  end

endmodule

// File: rtl/tslot_hbridge_pwm_chk.sv
module tslot_hbridge_pwm_chk #(
  parameter int NUM_CH = 4,
  parameter int MAX_ON = 200
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] fault_n,
  input logic [NUM_CH-1:0] drv_a,
  input logic [NUM_CH-1:0] drv_b
);

  localparam int RW = $clog2(MAX_ON + 2) + 1;

  assert_ab_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    (drv_a & drv_b) == '0);

  assert_single_channel_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv_a | drv_b));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (drv_a == '0) && (drv_b == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
      if (rst)                        run_len <= '0;
      else if (!(drv_a[g] | drv_b[g])) run_len <= '0;
      else if (run_len <= RW'(MAX_ON)) run_len <= run_len + 1'b1;
    end

    assert_on_time_cap_R2: assert property (@(posedge clk) disable iff (rst)
      run_len <= RW'(MAX_ON));

    assert_no_swap_a_R5: assert property (@(posedge clk) disable iff (rst)
      drv_a[g] |=> !drv_b[g]);

    assert_no_swap_b_R5: assert property (@(posedge clk) disable iff (rst)
      drv_b[g] |=> !drv_a[g]);

    assert_fault_cut_R8: assert property (@(posedge clk) disable iff (rst)
      !fault_n[g] |=> !(drv_a[g] | drv_b[g]));
  end

endmodule

bind tslot_hbridge_pwm tslot_hbridge_pwm_chk #(
  .NUM_CH(NUM_CH),
  .MAX_ON(MAX_ON)
) chk_i (
  .clk    (clk),
  .rst    (rst),
  .fault_n(fault_n),
  .drv_a  (drv_a),
  .drv_b  (drv_b)
);

// File: tb/tslot_hbridge_pwm_tb_top.sv
module tslot_hbridge_pwm_tb_top;

  localparam int NC = 4;
  localparam int CW = 8;
  localparam int SL = 12;
  localparam int MX = 10;
  localparam int FR = NC * SL;

  logic             clk = 1'b0;
  logic             rst;
  logic [NC*CW-1:0] speed_cmd;
  logic [NC-1:0]    dir_fwd;
  logic [NC-1:0]    fault_n;
  logic [NC-1:0]    drv_a;
  logic [NC-1:0]    drv_b;

  int    checks = 0;
  int    errors = 0;
  bit    checking = 1'b0;
  string tag = "R1 R2 R3 R4 R5";

  int ecnt;
  int lat_n  [NC];
  bit lat_dir[NC];
  bit kill   [NC];
  bit exp_a  [NC];
  bit exp_b  [NC];

  always #5 clk = ~clk;

  tslot_hbridge_pwm #(
    .NUM_CH   (NC),
    .CMD_W    (CW),
    .SLOT_CLKS(SL),
    .MAX_ON   (MX)
  ) dut_i (
    .clk      (clk),
    .rst      (rst),
    .speed_cmd(speed_cmd),
    .dir_fwd  (dir_fwd),
    .fault_n  (fault_n),
    .drv_a    (drv_a),
    .drv_b    (drv_b)
  );

  // arithmetic model: position inside the frame decides everything
  always @(posedge clk) begin
    if (rst) begin
      ecnt = 0;
      for (int k = 0; k < NC; k++) begin
        lat_n[k] = 0; lat_dir[k] = 1'b0; kill[k] = 1'b0;
        exp_a[k] = 1'b0; exp_b[k] = 1'b0;
      end
    end else begin
      ecnt = ecnt + 1;
      for (int k = 0; k < NC; k++) begin
        int  o;
        int  c;
        bit  act;
        o = ecnt - 2 - k * SL;
        if (o >= 0 && (o % FR) == 0) begin
          c          = int'(speed_cmd[k*CW +: CW]);
          lat_n[k]   = (c > MX) ? MX : c;
          lat_dir[k] = dir_fwd[k];
          kill[k]    = !fault_n[k];
        end else begin
          kill[k] = kill[k] | !fault_n[k];
        end
        act      = (o >= 1) && (((o - 1) % FR) < lat_n[k]);
        exp_a[k] = act &&  lat_dir[k] && !kill[k];
        exp_b[k] = act && !lat_dir[k] && !kill[k];
      end
    end
  end

  task automatic check_bit(input string req, input int ch, input string nm,
                           input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ch%0d %s at edge %0d: got %0b expected %0b",
               req, ch, nm, ecnt, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      for (int k = 0; k < NC; k++) begin
        check_bit(tag, k, "drv_a", drv_a[k], exp_a[k]);
        check_bit(tag, k, "drv_b", drv_b[k], exp_b[k]);
      end
      // R6: no shoot-through, one conducting motor at most
      checks++;
      if (((drv_a & drv_b) != '0) || ($countones(drv_a | drv_b) > 1)) begin
        errors++;
        $display("FAIL R6 overlap: got a=%b b=%b expected disjoint single channel",
                 drv_a, drv_b);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst       = 1'b1;
    speed_cmd = '0;
    dir_fwd   = '0;
    fault_n   = '1;
    // inputs active during reset must not reach the outputs (R9)
    repeat (2) @(negedge clk);
    speed_cmd = {NC{8'd5}};
    dir_fwd   = '1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < NC; k++) begin
      check_bit("R9", k, "drv_a", drv_a[k], 1'b0);
      check_bit("R9", k, "drv_b", drv_b[k], 1'b0);
    end
    rst      = 1'b0;
    checking = 1'b1;

    // sweep: every speed value, both directions (R1 R2 R3 R4 R5)
    tag = "R1 R2 R3 R4 R5";
    for (int pass = 0; pass < 2; pass++) begin
      for (int v = 0; v < 256; v++) begin
        for (int k = 0; k < NC; k++) begin
          speed_cmd[k*CW +: CW] = CW'(v);
          dir_fwd[k] = ((v + k + pass) % 2) == 0;
        end
        repeat (FR) @(negedge clk);
      end
    end

    // inputs churn every clock; only capture values count (R7)
    tag = "R7";
    for (int i = 0; i < 40 * FR; i++) begin
      for (int k = 0; k < NC; k++) begin
        speed_cmd[k*CW +: CW] = CW'((i * 29 + k * 53 + (i / 7) * 11) % 256);
        dir_fwd[k] = ((i * 3 + k) % 5) < 2;
      end
      @(negedge clk);
    end

    // scattered faults plus one held across a capture (R8)
    tag = "R8";
    for (int k = 0; k < NC; k++) speed_cmd[k*CW +: CW] = CW'(4 + 2 * k);
    for (int i = 0; i < 40 * FR; i++) begin
      for (int k = 0; k < NC; k++) begin
        dir_fwd[k] = ((i / FR + k) % 2) == 0;
        fault_n[k] = !(((i * 7 + k * 13) % 29) == 0);
      end
      if (i >= 10 * FR && i < 12 * FR) fault_n[1] = 1'b0;
      @(negedge clk);
    end
    fault_n = '1;
    repeat (2 * FR) @(negedge clk);

    checking = 1'b0;
    finish_run();
  end

endmodule